// File: doc/BRIEF.md
# Tag Store with Sequential Next-Block Prefetch

This block models the tag side of a single-level cache whose lines are filled on every miss, with a prefetcher attached that fetches the block following the requested one. A requester presents one block address per transaction through a ready/valid handshake. One cycle after acceptance the block reports whether the address was resident. A miss always installs the block. The block can also queue one prefetch of the following block address, and that prefetch is looked up and installed in the very next cycle, before any further request is accepted. Memory latency is zero and no data is stored.

Every line carries a flag that marks it as brought in by a prefetch. The flag lets the block keep four running counters: demand hits, demand misses, prefetches installed and prefetches later consumed by a demand hit. Accuracy is consumed/installed and coverage follows from consumed against misses. A mode input selects the trigger policy. In the base mode only misses trigger a prefetch. In the alternate mode the first demand hit on a prefetch-installed line also triggers one.

Top module: `seqpf_cache`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and all four counters are 0. An accepted request yields `resp_valid`=1 for exactly the following cycle, and `resp_hit`=1 there only if the block was resident.
- R2: Every demand miss installs the requested block, so an immediate repeat of that address hits.
- R3: A demand miss triggers a prefetch of address+1, modulo 2^ADDR_W. While the prefetch is handled, `req_ready` is 0 for exactly one cycle, the cycle in which `resp_valid` is 1. A later demand for address+1 hits.
- R4: With `mode_pf_on_hit`=0, a demand hit triggers no prefetch: `req_ready` stays 1 in the response cycle and `cnt_pf_issued` is unchanged.
- R5: With `mode_pf_on_hit`=1, a demand hit on a line whose prefetch flag is set triggers a prefetch of address+1. A hit on a line whose flag is clear (demand-installed, or already consumed) does not.
- R6: A prefetch whose target is already resident changes no line and does not increment `cnt_pf_issued`.
- R7: `cnt_hit` and `cnt_miss` each increase by one per demand hit and per demand miss, and are visible in the response cycle.
- R8: A prefetch installation sets the line's prefetch flag. The first demand hit on that line clears the flag and increments `cnt_pf_used`. Later hits to the line leave `cnt_pf_used` unchanged, and `cnt_pf_used` never exceeds `cnt_pf_issued`.
- R9: The set index is the low log2(SETS) address bits and the tag is the rest. Two addresses with the same low bits but different upper bits evict each other when WAYS=1.
- R10: With WAYS>1, replacement picks an invalid way first and otherwise the least recently used way. A prefetch installation makes its line most recently used, exactly as a demand fill does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_pf_on_hit | input | 1 | 0: prefetch on miss only; 1: also on first hit to a prefetched line |
| req_valid | input | 1 | Demand request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Demand block address |
| resp_valid | output | 1 | Lookup result valid |
| resp_hit | output | 1 | 1 when the requested block was resident |
| cnt_hit | output | CNT_W | Demand hit count |
| cnt_miss | output | CNT_W | Demand miss count |
| cnt_pf_issued | output | CNT_W | Prefetches installed |
| cnt_pf_used | output | CNT_W | Prefetched lines consumed by a demand hit |

## Verification
The bench targets the ordering corners. A prefetch whose target is already resident must be dropped. A design that installs it anyway counts a phantom prefetch, and one that re-flags the line credits a false use later. The bench repeats hits on prefetched lines to catch a flag that is never cleared, which would inflate the used count and, in the alternate mode, keep prefetching on every hit. It also wraps the address at the top of the range and forces same-index conflicts. A two-way instance checks that a prefetch fill becomes most recently used: if it were not touched, the next conflicting miss would evict it and its demand would miss.

// File: rtl/seqpf_pkg.sv
package seqpf_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PF   = 1'b1
  } seqpf_state_e;
endpackage

// File: rtl/seqpf_tag_store.sv
module seqpf_tag_store #(
  parameter int SETS  = 8,
  parameter int WAYS  = 1,
  parameter int TAG_W = 9,
  parameter int IDX_W = 3,
  parameter int WAY_W = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [IDX_W-1:0]       set_idx,
  output logic [WAYS-1:0]        row_valid,
  output logic [WAYS-1:0]        row_pf,
  output logic [WAYS*TAG_W-1:0]  row_tag,
  output logic [WAYS*WAY_W-1:0]  row_age,
  input  logic                   wr_en,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic                   wr_fill,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   wr_pf_set,
  input  logic                   wr_pf_clr
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  pf_q    [SETS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAY_W-1:0] cur_age;

  assign cur_age   = age_q[set_idx][wr_way];
  assign row_valid = valid_q[set_idx];
  assign row_pf    = pf_q[set_idx];

  // Tag arrays: one plain RAM per way, no reset, single write port.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_fill && (wr_way == WAY_W'(w)))
        tag_mem[set_idx] <= wr_tag;
    end
    assign row_tag[w*TAG_W +: TAG_W] = tag_mem[set_idx];
    assign row_age[w*WAY_W +: WAY_W] = age_q[set_idx][w];
  end

  // Valid, prefetch flag and recency age per line.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        pf_q[s]    <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else if (wr_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == wr_way)
          age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < cur_age)
          age_q[set_idx][w] <= age_q[set_idx][w] + WAY_W'(1);
      end
      if (wr_fill) begin
        valid_q[set_idx][wr_way] <= 1'b1;
        pf_q[set_idx][wr_way]    <= wr_pf_set;
      end else if (wr_pf_clr) begin
        pf_q[set_idx][wr_way]    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seqpf_way_match.sv
module seqpf_way_match #(
  parameter int WAYS  = 1,
  parameter int TAG_W = 9,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]       row_valid,
  input  logic [WAYS-1:0]       row_pf,
  input  logic [WAYS*TAG_W-1:0] row_tag,
  input  logic [WAYS*WAY_W-1:0] row_age,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  hit_pf,
  output logic [WAY_W-1:0]      vic_way
);
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    hit_pf  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (row_valid[w] && (row_tag[w*TAG_W +: TAG_W] == look_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
        hit_pf  = row_pf[w];
      end
    end
  end

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    old_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (row_age[w*WAY_W +: WAY_W] == OLDEST) old_way = WAY_W'(w);
    end
    vic_way = any_free ? free_way : old_way;
  end
endmodule

// File: rtl/seqpf_cache.sv
module seqpf_cache
  import seqpf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WAYS   = 1,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pf_on_hit,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_miss,
  output logic [CNT_W-1:0]  cnt_pf_issued,
  output logic [CNT_W-1:0]  cnt_pf_used
);
  localparam int IDX_BITS = $clog2(SETS);
  localparam int IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
  localparam int TAG_W    = ADDR_W - IDX_BITS;
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

  seqpf_state_e      state_q;
  logic [ADDR_W-1:0] pf_addr_q;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0]  op_set;
  logic [TAG_W-1:0]  op_tag;
  logic              in_pf, accept, trigger;

  logic [WAYS-1:0]       row_valid, row_pf;
  logic [WAYS*TAG_W-1:0] row_tag;
  logic [WAYS*WAY_W-1:0] row_age;
  logic                  hit, hit_pf;
  logic [WAY_W-1:0]      hit_way, vic_way;

  logic                  wr_en, wr_fill, wr_pf_clr;
  logic [WAY_W-1:0]      wr_way;

  assign in_pf     = (state_q == ST_PF);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign op_addr   = in_pf ? pf_addr_q : req_addr;
  assign op_tag    = op_addr[ADDR_W-1:IDX_BITS];

  if (IDX_BITS > 0) begin : g_idx
    assign op_set = op_addr[IDX_W-1:0];
  end else begin : g_noidx
    assign op_set = '0;
  end

  seqpf_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .set_idx   (op_set),
    .row_valid (row_valid),
    .row_pf    (row_pf),
    .row_tag   (row_tag),
    .row_age   (row_age),
    .wr_en     (wr_en),
    .wr_way    (wr_way),
    .wr_fill   (wr_fill),
    .wr_tag    (op_tag),
    .wr_pf_set (in_pf),
    .wr_pf_clr (wr_pf_clr)
  );

  seqpf_way_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_match (
    .row_valid (row_valid),
    .row_pf    (row_pf),
    .row_tag   (row_tag),
    .row_age   (row_age),
    .look_tag  (op_tag),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_pf    (hit_pf),
    .vic_way   (vic_way)
  );

  // One lookup per cycle: demand in IDLE, queued prefetch in PF.
  assign wr_en     = accept || (in_pf && !hit);
  assign wr_fill   = !hit;
  assign wr_way    = hit ? hit_way : vic_way;
  assign wr_pf_clr = accept && hit && hit_pf;
  assign trigger   = accept && (!hit || (mode_pf_on_hit && hit_pf));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      pf_addr_q     <= '0;
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      cnt_hit       <= '0;
      cnt_miss      <= '0;
      cnt_pf_issued <= '0;
      cnt_pf_used   <= '0;
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_hit <= hit;
        if (hit) cnt_hit  <= cnt_hit + CNT_W'(1);
        else     cnt_miss <= cnt_miss + CNT_W'(1);
        if (hit && hit_pf) cnt_pf_used <= cnt_pf_used + CNT_W'(1);
      end
      if (in_pf && !hit) cnt_pf_issued <= cnt_pf_issued + CNT_W'(1);
      case (state_q)
        ST_IDLE: if (trigger) begin
          state_q   <= ST_PF;
          pf_addr_q <= req_addr + ADDR_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqpf_cache_chk.sv
module seqpf_cache_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_pf_on_hit,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [CNT_W-1:0] cnt_hit,
  input logic [CNT_W-1:0] cnt_miss,
  input logic [CNT_W-1:0] cnt_pf_issued,
  input logic [CNT_W-1:0] cnt_pf_used
);
  assert_resp_follows_accept_R1: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && req_ready));

  assert_miss_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> !req_ready);

  assert_stall_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready);

  assert_issue_in_pf_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_pf_issued != $past(cnt_pf_issued)) |-> $past(!req_ready));

  assert_base_hit_no_pf_R4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit && !$past(mode_pf_on_hit)) |-> req_ready);

  assert_miss_count_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (cnt_miss == $past(cnt_miss) + CNT_W'(1)));

  assert_hit_count_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (cnt_hit == $past(cnt_hit) + CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst) begin
      assert_used_le_issued_R8: assert (cnt_pf_used <= cnt_pf_issued);
    end
  end
endmodule

bind seqpf_cache seqpf_cache_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_pf_on_hit (mode_pf_on_hit),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .resp_valid     (resp_valid),
  .resp_hit       (resp_hit),
  .cnt_hit        (cnt_hit),
  .cnt_miss       (cnt_miss),
  .cnt_pf_issued  (cnt_pf_issued),
  .cnt_pf_used    (cnt_pf_used)
);

// File: tb/seqpf_cache_tb.sv
`timescale 1ns/1ps
module seqpf_cache_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        mode;
  logic [11:0] addr;
  logic        v0, v1;
  logic        rdy0, rdy1, rv0, rv1, rh0, rh1;
  logic [15:0] h0, m0, pi0, pu0, h1, m1, pi1, pu1;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  seqpf_cache #(.ADDR_W(12), .SETS(8), .WAYS(1), .CNT_W(16)) u_dut (
    .clk(clk), .rst(rst), .mode_pf_on_hit(mode), .req_valid(v0), .req_ready(rdy0),
    .req_addr(addr), .resp_valid(rv0), .resp_hit(rh0), .cnt_hit(h0), .cnt_miss(m0),
    .cnt_pf_issued(pi0), .cnt_pf_used(pu0));

  seqpf_cache #(.ADDR_W(12), .SETS(4), .WAYS(2), .CNT_W(16)) u_dut_lru (
    .clk(clk), .rst(rst), .mode_pf_on_hit(mode), .req_valid(v1), .req_ready(rdy1),
    .req_addr(addr), .resp_valid(rv1), .resp_hit(rh1), .cnt_hit(h1), .cnt_miss(m1),
    .cnt_pf_issued(pi1), .cnt_pf_used(pu1));

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt(input int sel, input int k);
    logic [15:0] r;
    case (k)
      0: r = (sel == 0) ? h0  : h1;
      1: r = (sel == 0) ? m0  : m1;
      2: r = (sel == 0) ? pi0 : pi1;
      default: r = (sel == 0) ? pu0 : pu1;
    endcase
    return {16'h0, r};
  endfunction

  // One demand transaction; returns hit and whether a prefetch slot followed.
  task automatic access(input int sel, input logic [11:0] a, output logic hit,
                        output logic stalled);
    @(negedge clk);
    while (!((sel == 0) ? rdy0 : rdy1)) @(negedge clk);
    addr = a;
    if (sel == 0) v0 = 1'b1; else v1 = 1'b1;
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    chk("R1", "resp_valid after accept", (sel == 0) ? rv0 : rv1, 1);
    hit     = (sel == 0) ? rh0 : rh1;
    stalled = !((sel == 0) ? rdy0 : rdy1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk("R1", "ready after reset", (s == 0) ? rdy0 : rdy1, 1);
      chk("R1", "resp_valid after reset", (s == 0) ? rv0 : rv1, 0);
      for (int k = 0; k < 4; k++) chk("R1", "counter after reset", cnt(s, k), 0);
    end
  endtask

  task automatic t_miss_next();
    logic h, st;
    access(0, 12'h010, h, st);
    chk("R1", "first access misses", h, 0);
    chk("R3", "miss opens prefetch slot", st, 1);
    access(0, 12'h011, h, st);
    chk("R3", "next block was prefetched", h, 1);
    chk("R4", "base mode hit no prefetch slot", st, 0);
    chk("R8", "first use counted", cnt(0, 3), 1);
    access(0, 12'h010, h, st);
    chk("R2", "missed block installed", h, 1);
    access(0, 12'h011, h, st);
    chk("R8", "second hit not counted as use", cnt(0, 3), 1);
    chk("R7", "hit count", cnt(0, 0), 3);
    chk("R7", "miss count", cnt(0, 1), 1);
    chk("R4", "issued count", cnt(0, 2), 1);
  endtask

  task automatic t_drop();
    logic h, st;
    logic [31:0] pi, pu;
    access(0, 12'h051, h, st);
    chk("R2", "new block misses", h, 0);
    pi = cnt(0, 2);
    access(0, 12'h050, h, st);
    chk("R3", "miss stalls even if target resident", st, 1);
    chk("R6", "resident target not counted", cnt(0, 2), pi);
    pu = cnt(0, 3);
    access(0, 12'h051, h, st);
    chk("R6", "resident line still hits", h, 1);
    chk("R6", "dropped prefetch left flag clear", cnt(0, 3), pu);
  endtask

  task automatic t_conflict();
    logic h, st;
    access(0, 12'h060, h, st);
    chk("R9", "0x060 misses", h, 0);
    access(0, 12'h068, h, st);
    chk("R9", "0x068 same index misses", h, 0);
    access(0, 12'h060, h, st);
    chk("R9", "0x060 was evicted", h, 0);
    access(0, 12'h061, h, st);
    chk("R9", "neighbour index untouched", h, 1);
  endtask

  task automatic t_hit_mode();
    logic h, st;
    logic [31:0] pi, pu;
    mode = 1'b1;
    access(0, 12'h080, h, st);
    pi = cnt(0, 2);
    pu = cnt(0, 3);
    access(0, 12'h081, h, st);
    chk("R5", "hit on prefetched line", h, 1);
    chk("R5", "prefetched hit opens slot", st, 1);
    chk("R5", "chained prefetch installed", cnt(0, 2), pi + 1);
    access(0, 12'h082, h, st);
    chk("R5", "chained block hits", h, 1);
    chk("R5", "chain continues", st, 1);
    access(0, 12'h082, h, st);
    chk("R5", "consumed line no further prefetch", st, 0);
    chk("R8", "two uses counted", cnt(0, 3), pu + 2);
    access(0, 12'h080, h, st);
    chk("R5", "demand line hit no prefetch", st, 0);
    mode = 1'b0;
  endtask

  task automatic t_wrap();
    logic h, st;
    access(0, 12'hFFF, h, st);
    chk("R3", "top address misses", h, 0);
    access(0, 12'h000, h, st);
    chk("R3", "prefetch wraps to zero", h, 1);
  endtask

  task automatic t_lru();
    logic h, st;
    access(1, 12'h100, h, st); chk("R10", "A miss", h, 0);
    access(1, 12'h104, h, st); chk("R10", "B fills free way", h, 0);
    access(1, 12'h100, h, st); chk("R10", "A kept with B", h, 1);
    access(1, 12'h108, h, st); chk("R10", "C miss", h, 0);
    access(1, 12'h100, h, st); chk("R10", "A was MRU, survives", h, 1);
    access(1, 12'h104, h, st); chk("R10", "B evicted as LRU", h, 0);
    access(1, 12'h108, h, st); chk("R10", "C evicted as LRU", h, 0);
    access(1, 12'h202, h, st);
    access(1, 12'h206, h, st);
    access(1, 12'h209, h, st);
    access(1, 12'h202, h, st); chk("R10", "prefetch fill evicted LRU line", h, 0);
    access(1, 12'h20A, h, st); chk("R10", "prefetch fill was MRU", h, 1);
    access(1, 12'h206, h, st); chk("R10", "older line evicted", h, 0);
  endtask

  initial begin
    rst = 1'b1; mode = 1'b0; addr = '0; v0 = 1'b0; v1 = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_next();
    t_drop();
    t_conflict();
    t_hit_mode();
    t_wrap();
    t_lru();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule